// File: doc/BRIEF.md
# Three-Port General-Purpose Register File

This block is the integer register file of a small 32-bit load/store processor. It holds thirty-two word-wide entries. Two read ports and one write port let a single arithmetic instruction fetch both source operands and retire one result in the same clock cycle. The two read ports are combinational. The write port updates its target on the rising clock edge. Each port selects an entry by a 5-bit register number.

Entry 0 is wired to zero. Reading it always gives zero, and writing to it is accepted but does nothing. Stored words have no type: signed integers, unsigned integers and addresses are all kept bit for bit. A synchronous reset clears the whole file. Operand forwarding, hazard detection and instruction decode are handled by the surrounding pipeline, not by this block.

Top module: `gpr_file`

## Requirements
- R1: The file holds 32 independent entries, addressed 0 to 31, each 32 bits wide. A write to one entry leaves every other entry unchanged.
- R2: Read port A (`rs_a_data`) shows the current content of entry `rs_a_idx` combinationally, in the same cycle the index is applied.
- R3: Read port B (`rs_b_data`) works the same way from `rs_b_idx`, fully independently of port A, including when both ports read the same entry.
- R4: When `wr_en` is 1 at a rising clock edge and `wr_idx` is not 0, entry `wr_idx` takes the value of `wr_data`. Both read ports show the new value from that edge onward.
- R5: When `wr_en` is 0 at a rising edge, no entry changes, whatever values `wr_idx` and `wr_data` carry.
- R6: Reading entry 0 on either port always returns 32'h0000_0000.
- R7: A write with `wr_idx` equal to 0 changes no entry. Entry 0 still reads as zero afterwards, and all other entries keep their values.
- R8: When a read port selects the same nonzero entry that is being written in the same cycle, the port returns the old value until the clock edge, and returns the new value after it.
- R9: When `rst` (active high) is 1 at a rising edge, every entry becomes zero. Reset takes priority over a write requested in the same cycle.
- R10: Every 32-bit pattern is stored and returned unchanged, including all ones, all zeros, a lone MSB and alternating bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset take effect on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| rs_a_idx | input | 5 | Register number for read port A |
| rs_a_data | output | 32 | Content of entry `rs_a_idx` |
| rs_b_idx | input | 5 | Register number for read port B |
| rs_b_data | output | 32 | Content of entry `rs_b_idx` |
| wr_en | input | 1 | Write request for the current cycle |
| wr_idx | input | 5 | Register number to write; 0 discards the write |
| wr_data | input | 32 | Word to be written |

## Verification
Both read ports are combinational, so a corrupted entry, or a write steered to the wrong entry, shows up on the ports in the very cycle that entry is selected after the faulty edge. Wrong internal state therefore stays hidden only until that register number is read.

The bench keeps its own model of all 32 entries and sweeps every index on both ports after each phase. A stray write, a lost write or a write that leaks into entry 0 is caught within one sweep. A read port that forwards write data early is caught by a check taken before the colliding edge.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  localparam int unsigned GPR_DATA_W = 32;
  localparam int unsigned GPR_ADDR_W = 5;

  // A write lands only when enabled and aimed at a nonzero entry.
  function automatic logic write_lands(input logic en,
                                       input logic [GPR_ADDR_W-1:0] idx);
    return en && (idx != '0);
  endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
  import gpr_file_pkg::*;
#(
  parameter int unsigned ADDR_W = GPR_ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] idx,
  output logic              fire,
  output logic [NREG-1:1]   sel
);
  assign fire = en && (idx != '0);

  for (genvar i = 1; i < NREG; i++) begin : g_sel
    assign sel[i] = fire && (idx == ADDR_W'(i));
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W,
  parameter int unsigned ADDR_W = GPR_ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:1]             sel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] bank
);
  for (genvar i = 0; i < NREG; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)         bank[i] <= '0;
        else if (sel[i]) bank[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W,
  parameter int unsigned ADDR_W = GPR_ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic [NREG-1:0][DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0]           idx,
  output logic [DATA_W-1:0]           data
);
  assign data = bank[idx];
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W,
  parameter int unsigned ADDR_W = GPR_ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rs_a_idx,
  output logic [DATA_W-1:0] rs_a_data,
  input  logic [ADDR_W-1:0] rs_b_idx,
  output logic [DATA_W-1:0] rs_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  // Named internal events, brought out for the checker.
  logic                        wr_fire;
  logic [NREG-1:1]             wr_sel;
  logic [NREG-1:0][DATA_W-1:0] bank;

  gpr_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en(wr_en), .idx(wr_idx), .fire(wr_fire), .sel(wr_sel)
  );

  gpr_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .sel(wr_sel), .wdata(wr_data), .bank(bank)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .bank(bank), .idx(rs_a_idx), .data(rs_a_data)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .bank(bank), .idx(rs_b_idx), .data(rs_b_data)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W,
  parameter int unsigned ADDR_W = GPR_ADDR_W,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rs_a_idx,
  input logic [DATA_W-1:0] rs_a_data,
  input logic [ADDR_W-1:0] rs_b_idx,
  input logic [DATA_W-1:0] rs_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_fire,
  input logic [NREG-1:1]   wr_sel
);
  a_r6_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (rs_a_idx == '0) |-> (rs_a_data == '0));

  a_r6_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rs_b_idx == '0) |-> (rs_b_data == '0));

  a_r7_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |-> (!wr_fire && wr_sel == '0));

  a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel) && (wr_fire == (wr_sel != '0)));

  a_r4_write_seen: assert property (@(posedge clk) disable iff (rst)
    write_lands(wr_en, wr_idx) |=>
      ((rs_a_idx != $past(wr_idx)) || (rs_a_data == $past(wr_data))));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rs_a_idx != $past(rs_a_idx)) || $stable(rs_a_data)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (rs_a_data == '0 && rs_b_data == '0));
endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .rs_a_idx(rs_a_idx), .rs_a_data(rs_a_data),
  .rs_b_idx(rs_b_idx), .rs_b_data(rs_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .wr_fire(wr_fire), .wr_sel(wr_sel)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rs_a_idx = '0, rs_b_idx = '0, wr_idx = '0;
  logic [31:0] rs_a_data, rs_b_data, wr_data = '0;
  logic        wr_en = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  gpr_file u_gpr_file (
    .clk(clk), .rst(rst),
    .rs_a_idx(rs_a_idx), .rs_a_data(rs_a_data),
    .rs_b_idx(rs_b_idx), .rs_b_data(rs_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] expect_rd(input logic [4:0] i);
    return (i == 5'd0) ? 32'd0 : model[i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge, update model at the edge.
  task automatic step(input bit r, input bit we, input logic [4:0] wi,
                      input logic [31:0] wd, input logic [4:0] ra,
                      input logic [4:0] rb, input string tag);
    @(negedge clk);
    rst = r; wr_en = we; wr_idx = wi; wr_data = wd;
    rs_a_idx = ra; rs_b_idx = rb;
    #1;
    check({tag, " port A"}, rs_a_data, expect_rd(ra));
    check({tag, " port B"}, rs_b_data, expect_rd(rb));
    @(posedge clk);
    if (r) for (int k = 0; k < 32; k++) model[k] = '0;
    else if (we && wi != 5'd0) model[wi] = wd;
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 32; k++)
      step(1'b0, 1'b0, 5'(k), 32'hDEAD_BEEF, 5'(k), 5'(31 - k), tag);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) model[k] = 32'hFFFF_FFFF;
    step(1'b1, 1'b0, 5'd0, '0, 5'd0, 5'd0, "R9 reset");
    step(1'b1, 1'b0, 5'd0, '0, 5'd1, 5'd31, "R9 reset");
    sweep("R9 cleared");

    // Fill every entry, including an attempt on entry 0 (R1, R7).
    for (int k = 0; k < 32; k++)
      step(1'b0, 1'b1, 5'(k), 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101),
           5'd0, 5'(k), "R7 fill");
    sweep("R1/R2/R3/R6 readback");

    // Bit patterns (R10).
    step(1'b0, 1'b1, 5'd3,  32'hFFFF_FFFF, 5'd3, 5'd3, "R10 ones");
    step(1'b0, 1'b1, 5'd4,  32'h8000_0000, 5'd3, 5'd3, "R10 ones");
    step(1'b0, 1'b1, 5'd5,  32'hAAAA_AAAA, 5'd4, 5'd4, "R10 msb");
    step(1'b0, 1'b1, 5'd6,  32'h5555_5555, 5'd5, 5'd4, "R10 alt");
    step(1'b0, 1'b1, 5'd7,  32'h0000_0000, 5'd6, 5'd5, "R10 alt");
    step(1'b0, 1'b1, 5'd0,  32'hFFFF_FFFF, 5'd7, 5'd6, "R10 zeros");
    sweep("R10 sweep");

    // Idle cycles with live address and data (R5).
    for (int k = 0; k < 32; k++)
      step(1'b0, 1'b0, 5'(k), 32'hC0DE_0000 | 32'(k), 5'(k), 5'd0, "R5 idle");
    sweep("R5 sweep");

    // Entry 0 writes of many patterns (R7).
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b1, 5'd0, 32'h1 << (k * 4), 5'd0, 5'd0, "R6 zero");
    sweep("R7 sweep");

    // Same-cycle collisions (R8): old value before the edge, new after (R4).
    for (int k = 1; k < 32; k++) begin
      step(1'b0, 1'b1, 5'(k), ~(32'(k) << 8), 5'(k), 5'(k), "R8 collide");
      step(1'b0, 1'b0, 5'(k), '0, 5'(k), 5'(k), "R4 after");
    end

    // Reset wins over a same-cycle write (R9).
    step(1'b1, 1'b1, 5'd9, 32'h9999_9999, 5'd9, 5'd8, "R9 pre");
    step(1'b0, 1'b0, 5'd0, '0, 5'd9, 5'd8, "R9 priority");
    sweep("R9 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule